// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a raster display from a small set of programmable registers. It advances one pixel position per clock. A pixel counter runs across each line and a line counter runs down each frame. From the two counters and the programmed limits the block drives horizontal and vertical sync, a data-enable for the visible area, a blanking flag and the current pixel coordinates.

Each axis has three registers: total, blank and sync. Every register holds two 16-bit values, and each value is stored minus one. The block supports a border region on the right and bottom edges. Border positions lie outside the visible area and are not yet blanked. The polarity of each sync output is selected separately.

Software holds the pipe disabled while it programs the timing, then enables the pipe. Writes made while the pipe runs are held in a pending copy and take effect at the next frame start. A frame therefore never mixes two timings.

Top module: `raster_timing_gen`

## Requirements
- R1: While the pipe is enabled, `pixX` starts at 0 and rises by one per clock. After it reaches the high half of the horizontal total register, it wraps to 0, so a line lasts that value plus one clocks.
- R2: `lineY` rises by one on each horizontal wrap. After the horizontal wrap of the line equal to the high half of the vertical total register, it wraps to 0.
- R3: `dataEn` is high exactly when `pixX` is at or below the low half of the horizontal total register and `lineY` is at or below the low half of the vertical total register.
- R4: Horizontal sync is active when `pixX` is greater than the low half (sync start) of the horizontal sync register and at or below its high half (sync end). The pulse width is therefore end minus start.
- R5: Vertical sync is active on every pixel of the lines whose `lineY` is greater than the low half of the vertical sync register and at or below its high half.
- R6: Register index 6 holds the polarity. Bit 0 set makes horizontal sync active-low, and bit 1 set makes vertical sync active-low. When a bit is clear, that sync is active-high.
- R7: `blankOut` is high when `pixX` is above the low half of the horizontal blank register or `lineY` is above the low half of the vertical blank register. Border positions have both `dataEn` and `blankOut` low.
- R8: Register indices are 0 for horizontal total, 1 for horizontal blank, 2 for horizontal sync, 3 for vertical total, 4 for vertical blank and 5 for vertical sync. Each register holds its end value in bits 31:16 and its start value in bits 15:0. After reset the registers describe 640x480 with no border: horizontal front porch 16, sync 96 and blank 160; vertical front porch 10, sync 2 and blank 45. Both syncs reset to active-high.
- R9: While `pipeEn` is low, `pixX` and `lineY` read 0, `dataEn` is low, `blankOut` is high and both syncs sit at their inactive level. When the pipe is enabled, the first pixel shown is (0,0).
- R10: A register write made while the pipe is enabled changes no output until the next frame start. From that frame on, the new value applies. A write made while the pipe is disabled applies from the moment the pipe is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pipeEn | input | 1 | Pipe enable; when low, holds the raster idle |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register index for the write |
| regWrData | input | 32 | Write data, end value in 31:16 and start value in 15:0 |
| pixX | output | 16 | Current pixel position in the line |
| lineY | output | 16 | Current line in the frame |
| hsyncOut | output | 1 | Horizontal sync, with programmed polarity |
| vsyncOut | output | 1 | Vertical sync, with programmed polarity |
| dataEn | output | 1 | High on visible pixels |
| blankOut | output | 1 | High on blanked positions |

## Verification
All outputs decode combinationally from the two counter registers and the active timing copy. A pixel's outputs are therefore valid in the same cycle the counters hold that position. Enabling the pipe shows pixel (0,0) before the next edge, and every clock edge after that advances one position.

The bench samples one time unit after each falling edge and numbers each sample k from the enable. It models the expected pixel as k modulo the line length, and the expected line from k divided by the line length. A write that lands mid-frame is modelled as taking effect at the sample index equal to the old frame length.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  // Register layout: two half-words per timing register.
  localparam int HW = 16;
  localparam int RW = 2 * HW;

  typedef struct packed {
    logic [HW-1:0] hi;
    logic [HW-1:0] lo;
  } pair_t;

  typedef struct packed {
    pair_t hTot;
    pair_t hBlk;
    pair_t hSyn;
    pair_t vTot;
    pair_t vBlk;
    pair_t vSyn;
    logic  hPolLow;
    logic  vPolLow;
  } timing_t;

  typedef enum logic [2:0] {
    REG_HTOT = 3'd0,
    REG_HBLK = 3'd1,
    REG_HSYN = 3'd2,
    REG_VTOT = 3'd3,
    REG_VBLK = 3'd4,
    REG_VSYN = 3'd5,
    REG_POL  = 3'd6
  } regSel_e;

  // Strobes from control to datapath and register bank.
  typedef struct packed {
    logic run;
    logic lineWrap;
    logic frameWrap;
    logic loadCfg;
  } strobe_t;

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter timing_t RST_CFG = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [2:0]    wrSel,
  input  logic [RW-1:0] wrData,
  input  logic          loadCfg,
  output timing_t       actCfg
);

  timing_t pendCfg;
  timing_t pendNext;

  always_comb begin
    pendNext = pendCfg;
    if (wrEn) begin
      case (regSel_e'(wrSel))
        REG_HTOT: pendNext.hTot = wrData;
        REG_HBLK: pendNext.hBlk = wrData;
        REG_HSYN: pendNext.hSyn = wrData;
        REG_VTOT: pendNext.vTot = wrData;
        REG_VBLK: pendNext.vBlk = wrData;
        REG_VSYN: pendNext.vSyn = wrData;
        REG_POL: begin
          pendNext.hPolLow = wrData[0];
          pendNext.vPolLow = wrData[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCfg <= RST_CFG;
      actCfg  <= RST_CFG;
    end else begin
      pendCfg <= pendNext;
      if (loadCfg) actCfg <= pendNext;
    end
  end

endmodule

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
(
  input  logic    pipeEn,
  input  logic    pixAtEnd,
  input  logic    lineAtEnd,
  output strobe_t strobe
);

  always_comb begin
    strobe.run       = pipeEn;
    strobe.lineWrap  = pipeEn && pixAtEnd;
    strobe.frameWrap = pipeEn && pixAtEnd && lineAtEnd;
    strobe.loadCfg   = !pipeEn || (pixAtEnd && lineAtEnd);
  end

endmodule

// File: rtl/rtg_datapath.sv
module rtg_datapath
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strobe,
  input  timing_t       cfg,
  output logic          pixAtEnd,
  output logic          lineAtEnd,
  output logic [HW-1:0] pixX,
  output logic [HW-1:0] lineY,
  output logic          hsyncOut,
  output logic          vsyncOut,
  output logic          dataEn,
  output logic          blankOut
);

  logic [HW-1:0] pixCnt;
  logic [HW-1:0] lineCnt;
  logic hsAct, vsAct, hBlank, vBlank;

  assign pixAtEnd  = pixCnt  >= cfg.hTot.hi;
  assign lineAtEnd = lineCnt >= cfg.vTot.hi;

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.run) begin
      pixCnt  <= '0;
      lineCnt <= '0;
    end else if (strobe.lineWrap) begin
      pixCnt  <= '0;
      lineCnt <= strobe.frameWrap ? '0 : lineCnt + 1'b1;
    end else begin
      pixCnt  <= pixCnt + 1'b1;
    end
  end

  always_comb begin
    hsAct  = (pixCnt  > cfg.hSyn.lo) && (pixCnt  <= cfg.hSyn.hi);
    vsAct  = (lineCnt > cfg.vSyn.lo) && (lineCnt <= cfg.vSyn.hi);
    hBlank = (pixCnt  > cfg.hBlk.lo) && (pixCnt  <= cfg.hBlk.hi);
    vBlank = (lineCnt > cfg.vBlk.lo) && (lineCnt <= cfg.vBlk.hi);
    pixX     = strobe.run ? pixCnt  : '0;
    lineY    = strobe.run ? lineCnt : '0;
    dataEn   = strobe.run && (pixCnt <= cfg.hTot.lo) && (lineCnt <= cfg.vTot.lo);
    blankOut = !strobe.run || hBlank || vBlank;
    hsyncOut = (strobe.run && hsAct) ^ cfg.hPolLow;
    vsyncOut = (strobe.run && vsAct) ^ cfg.vPolLow;
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int H_ACTIVE = 640,
  parameter int H_BORDER = 0,
  parameter int H_FPORCH = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BLANK  = 160,
  parameter int V_ACTIVE = 480,
  parameter int V_BORDER = 0,
  parameter int V_FPORCH = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BLANK  = 45
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pipeEn,
  input  logic          regWrEn,
  input  logic [2:0]    regSel,
  input  logic [31:0]   regWrData,
  output logic [15:0]   pixX,
  output logic [15:0]   lineY,
  output logic          hsyncOut,
  output logic          vsyncOut,
  output logic          dataEn,
  output logic          blankOut
);

  localparam int H_EDGE = H_ACTIVE + H_BORDER;
  localparam int V_EDGE = V_ACTIVE + V_BORDER;
  localparam int H_LAST = H_EDGE + H_BLANK - 1;
  localparam int V_LAST = V_EDGE + V_BLANK - 1;

  localparam timing_t RST_CFG = '{
    hTot: '{hi: HW'(H_LAST), lo: HW'(H_ACTIVE - 1)},
    hBlk: '{hi: HW'(H_LAST), lo: HW'(H_EDGE - 1)},
    hSyn: '{hi: HW'(H_EDGE + H_FPORCH + H_SYNC - 1), lo: HW'(H_EDGE + H_FPORCH - 1)},
    vTot: '{hi: HW'(V_LAST), lo: HW'(V_ACTIVE - 1)},
    vBlk: '{hi: HW'(V_LAST), lo: HW'(V_EDGE - 1)},
    vSyn: '{hi: HW'(V_EDGE + V_FPORCH + V_SYNC - 1), lo: HW'(V_EDGE + V_FPORCH - 1)},
    hPolLow: 1'b0,
    vPolLow: 1'b0
  };

  timing_t actCfg;
  strobe_t strobe;
  logic    pixAtEnd;
  logic    lineAtEnd;

  rtg_regs #(.RST_CFG(RST_CFG)) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (regWrEn),
    .wrSel   (regSel),
    .wrData  (regWrData),
    .loadCfg (strobe.loadCfg),
    .actCfg  (actCfg)
  );

  rtg_ctrl u_ctrl (
    .pipeEn    (pipeEn),
    .pixAtEnd  (pixAtEnd),
    .lineAtEnd (lineAtEnd),
    .strobe    (strobe)
  );

  rtg_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfg       (actCfg),
    .pixAtEnd  (pixAtEnd),
    .lineAtEnd (lineAtEnd),
    .pixX      (pixX),
    .lineY     (lineY),
    .hsyncOut  (hsyncOut),
    .vsyncOut  (vsyncOut),
    .dataEn    (dataEn),
    .blankOut  (blankOut)
  );

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          pipeEn,
  input logic [HW-1:0] pixX,
  input logic [HW-1:0] lineY,
  input logic          dataEn,
  input logic          hsyncOut,
  input timing_t       actCfg
);

  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !pipeEn |-> (!dataEn && pixX == '0 && lineY == '0)); // R9

  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pipeEn && pixX < actCfg.hTot.hi) |=> (!pipeEn || pixX == $past(pixX) + 1'b1)); // R1

  AST_PIX_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (pipeEn && pixX == actCfg.hTot.hi) |=> (pixX == '0)); // R1

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pipeEn && pixX < actCfg.hTot.hi) |=> (!pipeEn || lineY == $past(lineY))); // R2

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pipeEn && pixX == actCfg.hTot.hi && lineY < actCfg.vTot.hi)
      |=> (!pipeEn || lineY == $past(lineY) + 1'b1)); // R2

  AST_DE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> (pixX <= actCfg.hTot.lo && lineY <= actCfg.vTot.lo)); // R3

  AST_HS_BEFORE: assert property (@(posedge clk) disable iff (!rstN)
    (pipeEn && pixX <= actCfg.hSyn.lo) |-> (hsyncOut == actCfg.hPolLow)); // R4

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pipeEn && !(pixX == actCfg.hTot.hi && lineY == actCfg.vTot.hi))
      |=> $stable(actCfg)); // R10

endmodule

bind raster_timing_gen rtg_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pipeEn   (pipeEn),
  .pixX     (pixX),
  .lineY    (lineY),
  .dataEn   (dataEn),
  .hsyncOut (hsyncOut),
  .actCfg   (actCfg)
);

// File: tb/raster_timing_gen_tb.sv
`timescale 1ns/1ps
module raster_timing_gen_tb;

  typedef int cfg_t [12];
  // fields: hAct hBord hFp hSync hBlank vAct vBord vFp vSync vBlank hPolLow vPolLow
  localparam int NV = 4;
  localparam int VEC [NV][12] = '{
    '{ 8, 2, 3, 4, 10, 6, 1, 2, 3, 7, 0, 0},
    '{12, 0, 2, 5,  9, 4, 0, 1, 1, 4, 1, 0},
    '{ 5, 3, 1, 2,  6, 3, 2, 1, 2, 5, 0, 1},
    '{10, 1, 1, 1,  4, 5, 0, 3, 2, 6, 1, 1}
  };
  localparam int DFLT [12] = '{640, 0, 16, 96, 160, 480, 0, 10, 2, 45, 0, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pipeEn = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regSel = '0;
  logic [31:0] regWrData = '0;
  logic [15:0] pixX, lineY;
  logic hsyncOut, vsyncOut, dataEn, blankOut;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  raster_timing_gen u_dut (
    .clk(clk), .rstN(rstN), .pipeEn(pipeEn), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .pixX(pixX), .lineY(lineY),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .dataEn(dataEn), .blankOut(blankOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] regVal(input cfg_t c, input int sel);
    int hT, vT, v;
    hT = c[0] + c[1] + c[4];
    vT = c[5] + c[6] + c[9];
    case (sel)
      0: v = ((hT - 1) << 16) | (c[0] - 1);
      1: v = ((hT - 1) << 16) | (c[0] + c[1] - 1);
      2: v = ((c[0] + c[1] + c[2] + c[3] - 1) << 16) | (c[0] + c[1] + c[2] - 1);
      3: v = ((vT - 1) << 16) | (c[5] - 1);
      4: v = ((vT - 1) << 16) | (c[5] + c[6] - 1);
      5: v = ((c[5] + c[6] + c[7] + c[8] - 1) << 16) | (c[5] + c[6] + c[7] - 1);
      default: v = (c[11] << 1) | c[10];
    endcase
    return 32'(v);
  endfunction

  task automatic writeCfg(input cfg_t c);
    for (int s = 0; s < 7; s++) begin
      @(negedge clk);
      regWrEn = 1'b1;
      regSel = 3'(s);
      regWrData = regVal(c, s);
    end
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Runs from enable; the frame of a is followed by frames of b.
  task automatic runCheck(input cfg_t a, input cfg_t b, input int nSamp,
                          input int writeAt, input string tag);
    int errCnt [6];
    int fAct [6];
    int fExp [6];
    int act [6];
    int exp [6];
    int frameA, hTA, measLine, measFrame;
    cfg_t c;
    hTA = a[0] + a[1] + a[4];
    frameA = hTA * (a[5] + a[6] + a[9]);
    measLine = -1;
    measFrame = -1;
    for (int i = 0; i < 6; i++) begin errCnt[i] = 0; fAct[i] = 0; fExp[i] = 0; end
    @(negedge clk);
    pipeEn = 1'b1;
    for (int k = 0; k < nSamp; k++) begin
      int kk, hT, vT, x, y, hs0, vs0;
      #1;
      if (k < frameA) begin c = a; kk = k; end
      else begin c = b; kk = k - frameA; end
      hT = c[0] + c[1] + c[4];
      vT = c[5] + c[6] + c[9];
      x = kk % hT;
      y = (kk / hT) % vT;
      hs0 = c[0] + c[1] + c[2];
      vs0 = c[5] + c[6] + c[7];
      exp[0] = x * 65536 + y;
      act[0] = int'(pixX) * 65536 + int'(lineY);
      exp[1] = (x < c[0] && y < c[5]) ? 1 : 0;
      act[1] = int'(dataEn);
      exp[2] = ((x >= hs0 && x < hs0 + c[3]) ? 1 : 0) ^ c[10];
      act[2] = int'(hsyncOut);
      exp[3] = ((y >= vs0 && y < vs0 + c[8]) ? 1 : 0) ^ c[11];
      act[3] = int'(vsyncOut);
      exp[4] = (x >= c[0] + c[1] || y >= c[5] + c[6]) ? 1 : 0;
      act[4] = int'(blankOut);
      // border positions: neither visible nor blanked
      exp[5] = ((x >= c[0] && x < c[0] + c[1] && y < c[5] + c[6]) ||
                (y >= c[5] && y < c[5] + c[6] && x < c[0] + c[1])) ? 0 : act[1] | act[4];
      act[5] = act[1] | act[4];
      for (int i = 0; i < 6; i++)
        if (act[i] != exp[i]) begin
          if (errCnt[i] == 0) begin fAct[i] = act[i]; fExp[i] = exp[i]; end
          errCnt[i]++;
        end
      if (k > 0 && pixX == 16'd0 && measLine < 0) measLine = k;
      if (k > 0 && pixX == 16'd0 && lineY == 16'd0 && measFrame < 0) measFrame = k;
      if (writeAt >= 0 && k >= writeAt && k < writeAt + 7) begin
        regWrEn = 1'b1;
        regSel = 3'(k - writeAt);
        regWrData = regVal(b, k - writeAt);
      end else begin
        regWrEn = 1'b0;
      end
      @(negedge clk);
    end
    regWrEn = 1'b0;
    pipeEn = 1'b0;
    check(errCnt[0] == 0, "R1 R2", {tag, " pixel/line position (x*65536+y)"}, fAct[0], fExp[0]);
    check(errCnt[1] == 0, "R3", {tag, " dataEn"}, fAct[1], fExp[1]);
    check(errCnt[2] == 0, (a[10] != 0) ? "R4 R6" : "R4", {tag, " hsync"}, fAct[2], fExp[2]);
    check(errCnt[3] == 0, (a[11] != 0) ? "R5 R6" : "R5", {tag, " vsync"}, fAct[3], fExp[3]);
    check(errCnt[4] == 0, "R7", {tag, " blankOut"}, fAct[4], fExp[4]);
    check(errCnt[5] == 0, "R7", {tag, " border de|blank"}, fAct[5], fExp[5]);
    check(measLine == hTA, "R1", {tag, " clocks per line"}, measLine, hTA);
    if (nSamp > frameA)
      check(measFrame == frameA, "R2", {tag, " clocks per frame"}, measFrame, frameA);
    if (writeAt >= 0)
      check(errCnt[0] == 0 && errCnt[2] == 0, "R10", {tag, " switch at frame start"},
            errCnt[0] + errCnt[2], 0);
  endtask

  initial begin
    #150000;
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    cfg_t c, d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R9: idle after reset
    check(dataEn == 1'b0, "R9", "reset dataEn", int'(dataEn), 0);
    check(hsyncOut == 1'b0 && vsyncOut == 1'b0, "R9", "reset sync level",
          int'({hsyncOut, vsyncOut}), 0);
    check(pixX == 16'd0 && lineY == 16'd0, "R9", "reset coords",
          int'(pixX) + int'(lineY), 0);
    check(blankOut == 1'b1, "R9", "reset blankOut", int'(blankOut), 1);

    // R8: default 640x480 timing, two lines
    for (int j = 0; j < 12; j++) c[j] = DFLT[j];
    runCheck(c, c, 1600, -1, "R8 default");

    // table of configurations, two frames each
    for (int i = 0; i < NV; i++) begin
      for (int j = 0; j < 12; j++) c[j] = VEC[i][j];
      writeCfg(c);
      runCheck(c, c, 2 * (c[0] + c[1] + c[4]) * (c[5] + c[6] + c[9]), -1,
               $sformatf("vec%0d", i));
    end

    // R9: dropping pipeEn mid-frame
    for (int j = 0; j < 12; j++) c[j] = VEC[0][j];
    writeCfg(c);
    @(negedge clk);
    pipeEn = 1'b1;
    repeat (37) @(negedge clk);
    #1;
    check(pixX != 16'd0 || lineY != 16'd0, "R9", "running before disable",
          int'(pixX) + int'(lineY), 1);
    pipeEn = 1'b0;
    #1;
    check(pixX == 16'd0 && lineY == 16'd0 && dataEn == 1'b0, "R9", "disable idles outputs",
          int'(pixX) + int'(lineY) + int'(dataEn), 0);
    @(negedge clk);
    #1;
    check(hsyncOut == 1'b0 && vsyncOut == 1'b0 && blankOut == 1'b1, "R9",
          "disable sync/blank", int'({hsyncOut, vsyncOut, blankOut}), 1);

    // R10: mid-frame rewrite applies only from the next frame
    for (int j = 0; j < 12; j++) d[j] = VEC[1][j];
    runCheck(c, d, 280 + 2 * 168, 5, "R10 switch");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule